// File: doc/BRIEF.md
# Watchdog Timer with Vector-Shared Service Address

This block is a watchdog. It counts clock cycles and raises a one-cycle reset request when software lets a full timeout period pass without servicing it. The block sits on a plain CPU bus with an address, a write strobe, a read strobe and byte-wide data. Software services the watchdog by writing to one address. That address is the same location as the low byte of the reset vector. A write of any value restarts the timeout. A read of that address returns the vector byte, which comes from a constant input, and tells software nothing about the watchdog.

The block has no interrupt output. Its only action is the reset request. Two high-voltage sense inputs show that monitor mode is active. While either one is high, the counter is held at zero. A wait-mode flag is accepted but has no effect, so a CPU that sleeps without servicing the watchdog is still reset.

Top module: `wdogVecClear`

## Requirements
- R1: Counting starts at zero. `rstReq` goes high for exactly one cycle `TIMEOUT_CYCLES` cycles after counting starts.
- R2: After a timeout the count restarts from zero by itself, so the next request follows `TIMEOUT_CYCLES` cycles later.
- R3: A bus write (`busWr`=1) to `SERVICE_ADDR` (default 0xFFFF) clears the count, whatever the data. The next request comes `TIMEOUT_CYCLES` cycles after the cycle that held the write.
- R4: A write to any other address does not change the timeout schedule.
- R5: While `busRd`=1 and `busAddr`=`SERVICE_ADDR`, `busRdata` equals `vecLowByte`. Any other read returns 0. A read does not change the timeout schedule.
- R6: While `monHvIrq` or `monHvRst` is 1, the count is held at zero and no request is raised. A full period starts from the last held cycle.
- R7: `waitMode`=1 does not change counting or the timing of requests.
- R8: A service write in the same cycle as the terminal count wins. No request is raised and a full new period begins.
- R9: While `rstN`=0 the count is zero and `rstReq` is 0. Counting starts at once when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Bus address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data (value ignored) |
| busRdata | output | DATA_W | Read data |
| vecLowByte | input | DATA_W | Constant low byte of the reset vector |
| monHvIrq | input | 1 | High voltage sensed on the interrupt pin |
| monHvRst | input | 1 | High voltage sensed on the reset pin |
| waitMode | input | 1 | CPU is in wait mode |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 20 and keeps the default 16-bit address and `SERVICE_ADDR` of 0xFFFF. The short period makes many timeouts possible in a short run: back-to-back automatic restarts, a service write that lands on the terminal cycle, and full periods after a monitor-mode hold or a reset in the middle of a count. The default period of 262128 cycles would allow only a few such events.

// File: rtl/wdogPkg.sv
package wdogPkg;
  typedef struct packed {
    logic clear;
    logic hold;
  } wdogStrobe_t;
endpackage

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SERVICE_ADDR = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] vecLowByte,
  input  logic              monHvIrq,
  input  logic              monHvRst,
  input  logic              waitMode,
  output logic [DATA_W-1:0] busRdata,
  output wdogStrobe_t       strobes
);
  logic addrHit;
  logic waitSeen;

  assign addrHit = (busAddr == SERVICE_ADDR);

  // Wait mode is deliberately not part of any strobe: counting continues.
  assign waitSeen = waitMode;

  always_comb begin
    strobes       = '0;
    strobes.hold  = monHvIrq | monHvRst;
    strobes.clear = busWr & addrHit;
  end

  // The vector byte is returned on a hit; no watchdog state is visible.
  assign busRdata = (busRd && addrHit) ? vecLowByte : '0;

  AST_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr) |-> !strobes.clear);                   // R5
  AST_WAIT_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (waitSeen && !monHvIrq && !monHvRst) |-> !strobes.hold); // R7
endmodule

// File: rtl/wdogCount.sv
module wdogCount
  import wdogPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 262128
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdogStrobe_t strobes,
  output logic        rstReq
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else if (strobes.hold || strobes.clear) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      rstReq <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      rstReq <= 1'b0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);                  // R1
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (cnt == '0));              // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (!rstReq && cnt == '0)); // R8
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> (!rstReq && cnt == '0));  // R6
endmodule

// File: rtl/wdogVecClear.sv
module wdogVecClear
  import wdogPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SERVICE_ADDR = '1,
  parameter int TIMEOUT_CYCLES = 262128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] vecLowByte,
  input  logic              monHvIrq,
  input  logic              monHvRst,
  input  logic              waitMode,
  output logic              rstReq
);
  wdogStrobe_t strobes;
  logic        unusedData;

  assign unusedData = ^busWdata;

  wdogCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SERVICE_ADDR(SERVICE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .vecLowByte(vecLowByte), .monHvIrq(monHvIrq), .monHvRst(monHvRst),
    .waitMode(waitMode), .busRdata(busRdata), .strobes(strobes)
  );

  wdogCount #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCount (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rstReq(rstReq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !rstReq); // R9
endmodule

// File: tb/sim_wdogVecClear.sv
`timescale 1ns/1ps
module sim_wdogVecClear;
  localparam int TERM = 20;

  logic clk = 1'b0;
  logic rstN;
  logic [15:0] busAddr;
  logic busWr, busRd;
  logic [7:0] busWdata, busRdata, vecLowByte;
  logic monHvIrq, monHvRst, waitMode;
  logic rstReq;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int expQ[$];
  string curTag = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdogVecClear #(.TIMEOUT_CYCLES(TERM)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .vecLowByte(vecLowByte),
    .monHvIrq(monHvIrq), .monHvRst(monHvRst), .waitMode(waitMode), .rstReq(rstReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Driver side: a restart seen at edge 'base' predicts a pulse TERM edges later.
  task automatic expectFrom(int base);
    expQ.delete();
    expQ.push_back(base + TERM);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    if (a == 16'hFFFF) expectFrom(cyc + 1);
    tick(1);
    busWr = 1'b0;
  endtask

  // Monitor: samples just after the rising edge and compares with the queue.
  always begin
    @(posedge clk); #1;
    if (rstN) begin
      if (rstReq) begin
        if (expQ.size() != 0 && expQ[0] == cyc) begin
          checks++;
          void'(expQ.pop_front());
          expQ.push_back(cyc + TERM); // R2 automatic restart
        end else begin
          errors++; checks++;
          $display("FAIL %s actual=pulse@%0d expected=%0d", curTag, cyc,
                   (expQ.size() != 0) ? expQ[0] : -1);
        end
      end else if (expQ.size() != 0 && expQ[0] < cyc) begin
        errors++; checks++;
        $display("FAIL %s actual=no pulse expected=pulse@%0d", curTag, expQ[0]);
        void'(expQ.pop_front());
      end
    end else if (rstReq !== 1'b0) begin
      errors++; checks++;
      $display("FAIL R9 actual=%b expected=0 during reset", rstReq);
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWr = 0; busRd = 0; busWdata = '0;
    vecLowByte = 8'h3C; monHvIrq = 0; monHvRst = 0; waitMode = 0;
    tick(3);
    check("R9 reset rstReq", rstReq, 0);
    check("R9 reset rdata", busRdata, 0);

    // R1/R2: start of counting and automatic restart
    curTag = "R1";
    rstN = 1'b1; expectFrom(cyc);
    tick(2 * TERM + 5);

    // R3: service writes with different data values
    curTag = "R3";
    busWrite(16'hFFFF, 8'h00);
    tick(7);
    busWrite(16'hFFFF, 8'hA5);
    tick(5);

    // R4: write elsewhere leaves the schedule alone
    curTag = "R4";
    busWrite(16'hFFFE, 8'hFF);
    busWrite(16'h0000, 8'h12);
    tick(TERM);

    // R5: reads return the vector byte and do not service
    curTag = "R5";
    busRd = 1'b1; busAddr = 16'hFFFF; #1;
    check("R5 read vector", busRdata, 8'h3C);
    vecLowByte = 8'hC7; #1;
    check("R5 read vector 2", busRdata, 8'hC7);
    tick(TERM);
    busAddr = 16'hFFFE; #1;
    check("R5 other read", busRdata, 0);
    busRd = 1'b0; busAddr = 16'hFFFF; #1;
    check("R5 no strobe", busRdata, 0);
    tick(TERM);

    // R7: wait mode keeps counting
    curTag = "R7";
    waitMode = 1'b1;
    tick(2 * TERM + 3);
    waitMode = 1'b0;

    // R6: monitor mode via either sense input
    curTag = "R6";
    monHvIrq = 1'b1; expQ.delete();
    tick(2 * TERM);
    monHvIrq = 1'b0; expectFrom(cyc);
    tick(TERM + 4);
    monHvRst = 1'b1; expQ.delete();
    tick(3 * TERM);
    check("R6 held no request", rstReq, 0);
    monHvRst = 1'b0; expectFrom(cyc);
    tick(TERM + 4);

    // R8: service on the terminal cycle wins
    curTag = "R8";
    while (cyc != expQ[0] - 1) tick(1);
    busWrite(16'hFFFF, 8'h5A);
    check("R8 no request", rstReq, 0);
    tick(TERM + 3);

    // R9: reset in the middle of a count
    curTag = "R9";
    tick(7);
    rstN = 1'b0; expQ.delete();
    tick(3);
    check("R9 mid reset", rstReq, 0);
    rstN = 1'b1; expectFrom(cyc);
    tick(TERM + 3);

    check("R2 schedule alive", (expQ.size() != 0 && expQ[0] > cyc) ? 1 : 0, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule